// File: doc/BRIEF.md
# Two-Client Burst Memory Arbiter

This block lets two clients share one burst-oriented SDRAM controller. The first client is a display-side reader that keeps its FIFO topped up with pixel data. The second is a capture-side writer whose FIFO must be drained into memory. Each client raises a request level and presents a 24-bit burst address. The arbiter picks one client and turns that address into a bank, row and column command. It then moves eight 32-bit words for that burst by driving the client FIFO's enable itself.

The arbiter waits in an idle state. When the controller reports ready and at least one client is requesting, it grants one client and issues a one-cycle command. When both clients request at once, the display reader wins. A request that arrives while a burst is in progress stays pending until the arbiter is idle again.

For a read, each word the controller marks valid is written into the display FIFO. The data is taken from a register loaded on the falling clock edge. For a write, the capture FIFO's read enable is pulsed once for each word of the burst. The FIFO output goes straight to the controller's write data, and a qualifier on that data trails each pulse by one cycle. A done indication from the controller returns the arbiter to idle.

Top module: `sdram_burst_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, no command is issued and none of `mem_rd_req`, `mem_wr_req`, `disp_fifo_we`, `cap_fifo_re` or `mem_wdata_valid` is high.
- R2: An edge at which the arbiter is idle, `mem_ready` is high and a client requests is a grant. A grant makes `mem_rd_req` (display) or `mem_wr_req` (capture) high for exactly the next cycle, and the two are never high together.
- R3: The command address is formed from the granted client's address at the grant edge. `mem_row` is address bits [14:6] (the line number) zero-extended to 13 bits. `mem_col` is address bits [5:0] (the burst index) followed by three zero bits. `mem_bank` is 2'b00. Address bits [23:15] have no effect.
- R4: When both clients request at the same grant edge, the display read is commanded first and the capture write is commanded after it completes.
- R5: No command is issued at an edge where `mem_ready` is low, however long a request is held.
- R6: While serving a read, `disp_fifo_we` is high in exactly those cycles in which `mem_rd_valid` is high, up to eight such cycles per burst. `disp_fifo_data` then equals the value on `mem_rdata` at the preceding falling clock edge. Valid cycles beyond the eighth are not written.
- R7: While serving a write, `cap_fifo_re` is high for exactly eight consecutive cycles, starting in the cycle of the write command. `mem_wdata_valid` is high one cycle after each of these, and `mem_wdata` equals `cap_fifo_data`.
- R8: `mem_done` ends a read or write service and returns the arbiter to idle. A request raised during a service is not acted on during it and is granted afterwards.
- R9: While idle, `mem_rd_valid` and `mem_done` have no effect: no FIFO enable rises and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Controller can accept a command |
| mem_done | input | 1 | Controller finished the current burst |
| mem_rd_valid | input | 1 | Read word present on mem_rdata |
| mem_rdata | input | 32 | Read data from memory |
| mem_rd_req | output | 1 | One-cycle read command |
| mem_wr_req | output | 1 | One-cycle write command |
| mem_bank | output | 2 | Bank address, always zero |
| mem_row | output | 13 | Row address (video line) |
| mem_col | output | 9 | Column address (burst index times 8) |
| mem_wdata | output | 32 | Write data to memory |
| mem_wdata_valid | output | 1 | mem_wdata holds a burst word |
| disp_req | input | 1 | Display reader requests a burst |
| disp_addr | input | 24 | Display burst address |
| disp_fifo_we | output | 1 | Write enable of the display FIFO |
| disp_fifo_data | output | 32 | Word written into the display FIFO |
| cap_req | input | 1 | Capture writer requests a burst |
| cap_addr | input | 24 | Capture burst address |
| cap_fifo_re | output | 1 | Read enable of the capture FIFO |
| cap_fifo_data | input | 32 | Capture FIFO output word |

## Verification
Single reads and single writes at different lines and burst indices confirm the address map on their own. One address has its top bits all set, which separates correct field extraction from a design that leaks unused bits into the row. Simultaneous requests separate fixed display priority from first-come or writer-first ordering. A request raised mid-burst shows that service is not preempted and that the pending request is still honoured. Gapped and over-long valid streams show that the FIFO write follows the valid strobe and stops at eight words. Holding `mem_ready` low and pulsing valid and done while idle expose designs that act on the wrong state.

// File: rtl/sdram_burst_arbiter.sv
module sdram_burst_arbiter #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 8,
  parameter int LINE_W    = 9,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ready,
  input  logic              mem_done,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [BANK_W-1:0] mem_bank,
  output logic [ROW_W-1:0]  mem_row,
  output logic [COL_W-1:0]  mem_col,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_valid,
  input  logic              disp_req,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic              disp_fifo_we,
  output logic [DATA_W-1:0] disp_fifo_data,
  input  logic              cap_req,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic              cap_fifo_re,
  input  logic [DATA_W-1:0] cap_fifo_data
);

  localparam int OFS_W  = $clog2(BURST_LEN);
  localparam int BIDX_W = COL_W - OFS_W;
  localparam int HI_LSB = BIDX_W + LINE_W;
  localparam int CNT_W  = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t             state;
  logic [CNT_W-1:0]   words;
  logic [DATA_W-1:0]  rdata_q;
  logic               grant_rd, grant_wr;
  logic [ADDR_W-1:0]  sel_addr;
  logic               unused_addr_hi;

  assign grant_rd = (state == S_IDLE) && mem_ready && disp_req;
  assign grant_wr = (state == S_IDLE) && mem_ready && !disp_req && cap_req;
  assign sel_addr = grant_rd ? disp_addr : cap_addr;
  assign unused_addr_hi = ^{disp_addr[ADDR_W-1:HI_LSB], cap_addr[ADDR_W-1:HI_LSB]};

  assign mem_bank       = '0;
  assign mem_wdata      = cap_fifo_data;
  assign disp_fifo_data = rdata_q;
  assign disp_fifo_we   = (state == S_READ) && mem_rd_valid && (words < LAST);
  assign cap_fifo_re    = (state == S_WRITE) && (words < LAST);

  always_ff @(negedge clk)
    rdata_q <= mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= S_IDLE;
      words           <= '0;
      mem_rd_req      <= 1'b0;
      mem_wr_req      <= 1'b0;
      mem_row         <= '0;
      mem_col         <= '0;
      mem_wdata_valid <= 1'b0;
    end else begin
      mem_rd_req      <= grant_rd;
      mem_wr_req      <= grant_wr;
      mem_wdata_valid <= cap_fifo_re;
      if (grant_rd || grant_wr) begin
        mem_row <= ROW_W'(sel_addr[BIDX_W +: LINE_W]);
        mem_col <= {sel_addr[BIDX_W-1:0], OFS_W'(0)};
        words   <= '0;
        state   <= grant_rd ? S_READ : S_WRITE;
      end else if (state != S_IDLE) begin
        if (mem_done) begin
          state <= S_IDLE;
          words <= '0;
        end else if (disp_fifo_we || cap_fifo_re) begin
          words <= words + 1'b1;
        end
      end
    end
  end

endmodule

module sdram_burst_arbiter_chk #(
  parameter int ADDR_W    = 24,
  parameter int BURST_LEN = 8,
  parameter int LINE_W    = 9,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic [ROW_W-1:0]  mem_row,
  input logic [COL_W-1:0]  mem_col,
  input logic              mem_wdata_valid,
  input logic              disp_req,
  input logic [ADDR_W-1:0] disp_addr,
  input logic              disp_fifo_we,
  input logic              cap_fifo_re
);
  localparam int OFS_W  = $clog2(BURST_LEN);
  localparam int BIDX_W = COL_W - OFS_W;

  a_r2_one_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);
  a_r2_no_dual_cmd: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));
  a_r5_ready_gate: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> $past(mem_ready));
  a_r4_display_first: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> !$past(disp_req));
  a_r3_row_map: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> mem_row == ROW_W'($past(disp_addr[BIDX_W +: LINE_W])));
  a_r3_col_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> mem_col[OFS_W-1:0] == '0);
  a_r6_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
    disp_fifo_we |-> mem_rd_valid);
  a_r7_one_client_steered: assert property (@(posedge clk) disable iff (rst)
    !(disp_fifo_we && cap_fifo_re));
  a_r7_wvalid_follows_re: assert property (@(posedge clk) disable iff (rst)
    mem_wdata_valid |-> $past(cap_fifo_re));
endmodule

bind sdram_burst_arbiter sdram_burst_arbiter_chk #(
  .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .LINE_W(LINE_W), .ROW_W(ROW_W), .COL_W(COL_W)
) chk_i (.*);

// File: tb/sdram_burst_arbiter_tb.sv
module sdram_burst_arbiter_tb_top;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, mem_ready, mem_done, mem_rd_valid;
  logic [31:0] mem_rdata, mem_wdata, disp_fifo_data, cap_fifo_data;
  logic mem_rd_req, mem_wr_req, mem_wdata_valid;
  logic [1:0] mem_bank;
  logic [12:0] mem_row;
  logic [8:0] mem_col;
  logic disp_req, cap_req, disp_fifo_we, cap_fifo_re;
  logic [23:0] disp_addr, cap_addr;

  sdram_burst_arbiter dut_i (.*);

  typedef struct packed {logic wr; logic [12:0] row; logic [8:0] col; logic [1:0] bank;} cmd_t;
  cmd_t exp_cmd[$];
  logic [31:0] exp_rd[$], exp_wr[$];
  int n_checks = 0, n_fail = 0;
  logic [31:0] rd_word = 32'hA500_0000, cap_word = 32'hC0DE_0000;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic cmd_t mk(logic wr, logic [23:0] a);
    return '{wr, 13'(a[14:6]), {a[5:0], 3'b000}, 2'b00};
  endfunction

  initial forever begin
    @(negedge clk); #0.5;
    if (!rst) begin
      if (mem_rd_req || mem_wr_req) begin
        if (exp_cmd.size() == 0) check("R2 unexpected command", 64'({mem_wr_req, mem_row, mem_col, mem_bank}), '1);
        else check("R2/R3/R4 command", 64'({mem_wr_req, mem_row, mem_col, mem_bank}), 64'(exp_cmd.pop_front()));
      end
      if (disp_fifo_we) begin
        if (exp_rd.size() == 0) check("R6 extra fifo write", 64'(disp_fifo_data), '1);
        else check("R6 read word", 64'(disp_fifo_data), 64'(exp_rd.pop_front()));
      end
      if (mem_wdata_valid) begin
        if (exp_wr.size() == 0) check("R7 extra write word", 64'(mem_wdata), '1);
        else check("R7 write word", 64'(mem_wdata), 64'(exp_wr.pop_front()));
      end
    end
  end

  initial forever begin
    logic take;
    @(negedge clk); take = cap_fifo_re;
    @(posedge clk); #1;
    if (take) begin
      cap_word++;
      cap_fifo_data = cap_word;
      exp_wr.push_back(cap_word);
    end
  end

  task automatic serve(int gap, int extra);
    bit is_rd, wr_seen = 0;
    int re_cnt;
    do begin @(negedge clk); #0.5; end while (!(mem_rd_req || mem_wr_req));
    is_rd = mem_rd_req;
    re_cnt = int'(cap_fifo_re);
    @(posedge clk); #1;
    if (is_rd) begin
      disp_req = 0;
      for (int k = 0; k < 8 + extra; k++) begin
        mem_rd_valid = 1; mem_rdata = rd_word;
        if (k < 8) exp_rd.push_back(rd_word);
        rd_word++;
        @(negedge clk); #0.5; if (cap_fifo_re) wr_seen = 1;
        @(posedge clk); #1;
        if (gap != 0) begin mem_rd_valid = 0; @(posedge clk); #1; end
      end
      mem_rd_valid = 0; mem_done = 1;
      @(posedge clk); #1; mem_done = 0;
      check("R8 no write steering during read", 64'(wr_seen), 0);
    end else begin
      cap_req = 0;
      repeat (12) begin @(negedge clk); #0.5; if (cap_fifo_re) re_cnt++; end
      @(posedge clk); #1; mem_done = 1;
      @(posedge clk); #1; mem_done = 0;
      check("R7 read-enable pulses", 64'(re_cnt), 8);
    end
  endtask

  task automatic run_all();
    logic [23:0] a;
    rst = 1; mem_ready = 1; mem_done = 0; mem_rd_valid = 0; mem_rdata = 0;
    disp_req = 0; cap_req = 0; disp_addr = 0; cap_addr = 0; cap_fifo_data = cap_word;
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    check("R1 reset outputs", 64'({mem_rd_req, mem_wr_req, disp_fifo_we, cap_fifo_re, mem_wdata_valid}), 0);
    @(posedge clk); #1; rst = 0;
    @(negedge clk); #0.5;
    check("R1 first cycle idle", 64'({mem_rd_req, mem_wr_req, disp_fifo_we, cap_fifo_re}), 0);

    a = {9'h000, 9'd37, 6'd5};
    exp_cmd.push_back(mk(0, a)); disp_addr = a; disp_req = 1; serve(0, 0);
    a = {9'h000, 9'd506, 6'd44};
    exp_cmd.push_back(mk(1, a)); cap_addr = a; cap_req = 1; serve(0, 0);

    exp_cmd.push_back(mk(0, {9'h000, 9'd1, 6'd0}));
    exp_cmd.push_back(mk(1, {9'h000, 9'd2, 6'd1}));
    @(posedge clk); #1;
    disp_addr = {9'h000, 9'd1, 6'd0}; cap_addr = {9'h000, 9'd2, 6'd1};
    disp_req = 1; cap_req = 1;
    serve(0, 0); serve(0, 0);

    mem_ready = 0; a = {9'h000, 9'd100, 6'd10};
    exp_cmd.push_back(mk(0, a)); disp_addr = a; disp_req = 1;
    repeat (6) begin @(negedge clk); #0.5; check("R5 no command when not ready", 64'(mem_rd_req), 0); end
    @(posedge clk); #1; mem_ready = 1;
    serve(0, 0);

    @(posedge clk); #1; mem_rd_valid = 1; mem_done = 1;
    repeat (3) begin @(negedge clk); #0.5;
      check("R9 idle ignores valid/done", 64'({disp_fifo_we, mem_rd_req, mem_wr_req}), 0); end
    @(posedge clk); #1; mem_rd_valid = 0; mem_done = 0;

    a = {9'h1FF, 9'd200, 6'd63};
    exp_cmd.push_back(mk(0, a)); disp_addr = a; disp_req = 1; serve(0, 0);

    exp_cmd.push_back(mk(0, {9'h000, 9'd300, 6'd7}));
    exp_cmd.push_back(mk(1, {9'h0AA, 9'd301, 6'd8}));
    disp_addr = {9'h000, 9'd300, 6'd7}; disp_req = 1;
    fork
      serve(0, 0);
      begin repeat (4) @(posedge clk); #1; cap_addr = {9'h0AA, 9'd301, 6'd8}; cap_req = 1; end
    join
    serve(0, 0);

    a = {9'h000, 9'd12, 6'd33};
    exp_cmd.push_back(mk(0, a)); disp_addr = a; disp_req = 1; serve(1, 3);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    check("R2 all commands issued", 64'(exp_cmd.size()), 0);
    check("R6 all read words written", 64'(exp_rd.size()), 0);
    check("R7 all write words sent", 64'(exp_wr.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule